// File: doc/BRIEF.md
# Performance Event Counter Unit

This block keeps a small, parameterised bank of 32-bit event counters next to one free-standing cycle counter. Every clock it is told whether an instruction retired, whether a processor cycle elapsed and whether a broadcast event arrived. A broadcast event carries an 8-bit code and a 32-bit count. The block is also told the current privilege level, PL0 or PL1. Each event counter has its own type register. The type register picks the event code to follow and can mute counting at either privilege level. The cycle counter holds position 31 in every per-counter mask.

Software reaches the block through a flat register port with word addresses. It can start and stop the whole unit. It can enable or disable single counters, zero whole groups, preload values and pulse counters by software. Overflow status bits are sticky. A level interrupt is raised for each overflow whose interrupt enable is set. Read data comes back one cycle after the read strobe, flagged by a valid pulse.

Top module: `pmc_unit`

## Requirements
- R1: While bit 0 of the control register (address 0x00) is clear, no event counter and not the cycle counter advances, whatever events arrive.
- R2: A control write with bit 1 set zeroes every event counter and leaves the cycle counter unchanged. A control write with bit 2 set zeroes only the cycle counter. A control read returns bit 0 (run) and bit 3 (divide).
- R3: With control bit 3 set, the cycle counter (address 0x07) advances once per 64 cycle strobes, counted from the write that set the bit. With the bit clear it advances on every strobe. Event counters that follow cycles are never divided.
- R4: Writing ones to address 0x01 enables counters and writing ones to address 0x02 disables them. Bit n is event counter n and bit 31 is the cycle counter. Both addresses read back the mask, and bits with no counter read as zero. A disabled counter holds its value and resumes from that value when enabled again.
- R5: Writing a one in bit n of address 0x06 adds exactly one to event counter n. This happens only if the counter's code is 0x00, the counter is enabled and the unit is running at the time of the write. Writes that fail a condition are dropped for good.
- R6: Event type registers sit at 0x20+n: bits 7:0 hold the code, bit 8 mutes PL0 and bit 9 mutes PL1. Code 0x08 counts retired instructions and code 0x11 counts cycle strobes. Any other code reads back as written and moves only on a broadcast whose code is equal to it.
- R7: A broadcast whose code matches a counter's nonzero code adds the 32-bit count in one step, modulo 2^32. For example, 5 plus 0xFFFFFFFF leaves 4.
- R8: Any wrap of counter n past 0xFFFFFFFF sets bit n of the overflow status (address 0x05). Writing a one to a status bit clears it, and writing a zero leaves it as it is.
- R9: The irq output goes high one cycle after an overflow bit is set whose interrupt enable is set. Interrupt enables are set at address 0x03 and cleared at 0x04, and both addresses read back the mask. A masked overflow does not raise irq.
- R10: While the privilege input (0 = PL0, 1 = PL1) selects a muted level, the counter neither advances nor records an overflow.
- R11: A counter value write (address 0x10+n) or a zeroing control write wins over an increment in the same cycle, and that increment is lost.
- R12: After reset every counter, mask and status bit is zero, the unit is stopped and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 1 | Current privilege level, 0 = PL0, 1 = PL1 |
| inst_ret | input | 1 | One instruction retired this cycle |
| cyc_tick | input | 1 | One processor cycle elapsed this cycle |
| bc_valid | input | 1 | Broadcast event present |
| bc_code | input | 8 | Broadcast event code |
| bc_count | input | 32 | Broadcast event count to add |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_re |
| irq | output | 1 | Overflow interrupt level |

## Verification
Two situations are hard to set up from the ports. The first is an overflow that the privilege filter must hold back. The second is a write that meets an increment on the same edge. For the first, the bench preloads a counter two below the wrap point and lets instructions retire at the muted level, then checks that the counter is still at its preloaded value and that its status bit is still clear. It then unmutes the other level, switches privilege and watches the wrap land. For the second, the bench drives the write strobe and the event strobe on the same edge, once for a value load and once for a zeroing control write. Each time it reads back only the written value.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int EV_W   = 8;
  localparam int CYC_BIT = 31;

  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 8'h01;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 8'h02;
  localparam logic [ADDR_W-1:0] A_IE_SET  = 8'h03;
  localparam logic [ADDR_W-1:0] A_IE_CLR  = 8'h04;
  localparam logic [ADDR_W-1:0] A_OVF     = 8'h05;
  localparam logic [ADDR_W-1:0] A_SWINC   = 8'h06;
  localparam logic [ADDR_W-1:0] A_CYC     = 8'h07;
  localparam logic [ADDR_W-1:0] A_CNT_BASE  = 8'h10;
  localparam logic [ADDR_W-1:0] A_TYPE_BASE = 8'h20;

  localparam logic [EV_W-1:0] EV_SWINC = 8'h00;
  localparam logic [EV_W-1:0] EV_INST  = 8'h08;
  localparam logic [EV_W-1:0] EV_CYC   = 8'h11;

  typedef struct packed {
    logic            mute_pl1;
    logic            mute_pl0;
    logic [EV_W-1:0] code;
  } evtype_t;

  localparam int ET_W = $bits(evtype_t);

  function automatic logic [ADDR_W-1:0] cnt_addr(input int n);
    return A_CNT_BASE + ADDR_W'(n);
  endfunction

  function automatic logic [ADDR_W-1:0] type_addr(input int n);
    return A_TYPE_BASE + ADDR_W'(n);
  endfunction
endpackage

// File: rtl/pmc_gate.sv
module pmc_gate import pmc_pkg::*; (
  input  evtype_t          etype,
  input  logic             glob_en,
  input  logic             cnt_en,
  input  logic             priv,
  input  logic             inst_ret,
  input  logic             cyc_tick,
  input  logic             bc_valid,
  input  logic [EV_W-1:0]  bc_code,
  input  logic [REG_W-1:0] bc_count,
  input  logic             sw_hit,
  output logic             step_en,
  output logic [REG_W-1:0] step
);
  logic allowed;
  logic bc_hit;
  logic src;

  // all three gates: unit running, counter enabled, privilege level not muted
  assign allowed = glob_en & cnt_en & ~(priv ? etype.mute_pl1 : etype.mute_pl0);
  assign bc_hit  = bc_valid && (bc_code == etype.code) && (etype.code != EV_SWINC);

  always_comb begin
    step = REG_W'(1);
    src  = 1'b0;
    if (bc_hit) begin
      step = bc_count;
      src  = 1'b1;
    end else begin
      case (etype.code)
        EV_SWINC: src = sw_hit;
        EV_INST:  src = inst_ret;
        EV_CYC:   src = cyc_tick;
        default:  src = 1'b0;
      endcase
    end
  end

  assign step_en = allowed & src;
endmodule

// File: rtl/pmc_acc.sv
module pmc_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W:0] sum;

  assign sum  = {1'b0, cnt} + {1'b0, add_val};
  // an increment that loses to a write cannot report a wrap
  assign wrap = add_en & ~clr & ~load & sum[W];

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (add_en) cnt <= sum[W-1:0];
  end
endmodule

// File: rtl/pmc_prescale.sv
module pmc_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic div_mode,
  input  logic tick_en,
  output logic pulse
);
  logic [DIV_LOG2-1:0] ps;

  always_ff @(posedge clk) begin
    if (rst || clr || !div_mode) ps <= '0;
    else if (tick_en)            ps <= ps + 1'b1;
  end

  assign pulse = tick_en & (~div_mode | (&ps));
endmodule

// File: rtl/pmc_unit.sv
module pmc_unit import pmc_pkg::*; #(
  parameter int NUM_CNT  = 4,
  parameter int DIV_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv,
  input  logic              inst_ret,
  input  logic              cyc_tick,
  input  logic              bc_valid,
  input  logic [EV_W-1:0]   bc_code,
  input  logic [REG_W-1:0]  bc_count,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_rvalid,
  output logic              irq
);
  localparam logic [REG_W-1:0] IMPL =
    (REG_W'(1) << CYC_BIT) | ((REG_W'(1) << NUM_CNT) - REG_W'(1));

  logic                     glob_en, div_mode;
  logic [REG_W-1:0]         cnten, inten, ovf, ovf_nx, wrap_vec, rd_mux;
  evtype_t [NUM_CNT-1:0]    etype_q;
  logic [NUM_CNT*REG_W-1:0] evcnt_flat;
  logic [NUM_CNT-1:0]       ev_wrap;
  logic [REG_W-1:0]         cyc_cnt;
  logic                     cyc_wrap, cyc_go, cyc_pulse;
  logic                     wr_ctrl, wr_swinc, wr_ovf, zero_ev, zero_cyc;

  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign wr_swinc = reg_we && (reg_addr == A_SWINC);
  assign wr_ovf   = reg_we && (reg_addr == A_OVF);
  assign zero_ev  = wr_ctrl & reg_wdata[1];
  assign zero_cyc = wr_ctrl & reg_wdata[2];

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic             step_en;
    logic [REG_W-1:0] step;

    pmc_gate u_gate (
      .etype   (etype_q[n]),
      .glob_en (glob_en),
      .cnt_en  (cnten[n]),
      .priv    (priv),
      .inst_ret(inst_ret),
      .cyc_tick(cyc_tick),
      .bc_valid(bc_valid),
      .bc_code (bc_code),
      .bc_count(bc_count),
      .sw_hit  (wr_swinc & reg_wdata[n]),
      .step_en (step_en),
      .step    (step)
    );

    pmc_acc #(.W(REG_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .clr     (zero_ev),
      .load    (reg_we && (reg_addr == cnt_addr(n))),
      .load_val(reg_wdata),
      .add_en  (step_en),
      .add_val (step),
      .cnt     (evcnt_flat[n*REG_W +: REG_W]),
      .wrap    (ev_wrap[n])
    );
  end

  assign cyc_go = glob_en & cnten[CYC_BIT] & cyc_tick;

  pmc_prescale #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk     (clk),
    .rst     (rst),
    .clr     (zero_cyc),
    .div_mode(div_mode),
    .tick_en (cyc_go),
    .pulse   (cyc_pulse)
  );

  pmc_acc #(.W(REG_W)) u_cyc (
    .clk     (clk),
    .rst     (rst),
    .clr     (zero_cyc),
    .load    (reg_we && (reg_addr == A_CYC)),
    .load_val(reg_wdata),
    .add_en  (cyc_pulse),
    .add_val (REG_W'(1)),
    .cnt     (cyc_cnt),
    .wrap    (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    for (int n = 0; n < NUM_CNT; n++) wrap_vec[n] = ev_wrap[n];
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  // a fresh wrap wins over a clearing write in the same cycle
  assign ovf_nx = ((ovf & ~(wr_ovf ? reg_wdata : '0)) | wrap_vec) & IMPL;

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en  <= 1'b0;
      div_mode <= 1'b0;
      cnten    <= '0;
      inten    <= '0;
      ovf      <= '0;
      irq      <= 1'b0;
      etype_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        glob_en  <= reg_wdata[0];
        div_mode <= reg_wdata[3];
      end
      if (reg_we && reg_addr == A_EN_SET)      cnten <= (cnten | reg_wdata) & IMPL;
      else if (reg_we && reg_addr == A_EN_CLR) cnten <= cnten & ~reg_wdata;
      if (reg_we && reg_addr == A_IE_SET)      inten <= (inten | reg_wdata) & IMPL;
      else if (reg_we && reg_addr == A_IE_CLR) inten <= inten & ~reg_wdata;
      ovf <= ovf_nx;
      irq <= |(ovf & inten);
      for (int n = 0; n < NUM_CNT; n++)
        if (reg_we && reg_addr == type_addr(n)) etype_q[n] <= evtype_t'(reg_wdata[ET_W-1:0]);
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:             rd_mux = REG_W'({div_mode, 2'b00, glob_en});
      A_EN_SET, A_EN_CLR: rd_mux = cnten;
      A_IE_SET, A_IE_CLR: rd_mux = inten;
      A_OVF:              rd_mux = ovf;
      A_CYC:              rd_mux = cyc_cnt;
      default:            rd_mux = '0;
    endcase
    for (int n = 0; n < NUM_CNT; n++) begin
      if (reg_addr == cnt_addr(n))  rd_mux = evcnt_flat[n*REG_W +: REG_W];
      if (reg_addr == type_addr(n)) rd_mux = REG_W'(etype_q[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_re;
      if (reg_re) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pmc_unit_chk.sv
module pmc_unit_chk import pmc_pkg::*; #(
  parameter int NUM_CNT = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_we,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [REG_W-1:0]         reg_wdata,
  input logic                     glob_en,
  input logic [REG_W-1:0]         cnten,
  input logic [REG_W-1:0]         inten,
  input logic [REG_W-1:0]         ovf,
  input logic [NUM_CNT*REG_W-1:0] evcnt_flat,
  input logic [REG_W-1:0]         cyc_cnt,
  input logic                     irq
);
  localparam logic [REG_W-1:0] IMPL =
    (REG_W'(1) << CYC_BIT) | ((REG_W'(1) << NUM_CNT) - REG_W'(1));

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!glob_en && !reg_we) |=> ($stable(evcnt_flat) && $stable(cyc_cnt))); // R1

  AST_CYC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CTRL && reg_wdata[2]) |=> (cyc_cnt == '0)); // R2

  AST_EVT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CTRL && reg_wdata[1]) |=> (evcnt_flat == '0)); // R2

  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_EN_SET) |=> ((cnten & $past(reg_wdata) & IMPL) == ($past(reg_wdata) & IMPL))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == A_OVF) |=> ((ovf & $past(ovf)) == $past(ovf))); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (inten == '0) |=> !irq); // R9

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(ovf & inten)) |=> irq); // R9
endmodule

bind pmc_unit pmc_unit_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .glob_en   (glob_en),
  .cnten     (cnten),
  .inten     (inten),
  .ovf       (ovf),
  .evcnt_flat(evcnt_flat),
  .cyc_cnt   (cyc_cnt),
  .irq       (irq)
);

// File: tb/pmc_unit_tb.sv
module pmc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv = 1'b0, inst_ret = 1'b0, cyc_tick = 1'b0;
  logic        bc_valid = 1'b0;
  logic [7:0]  bc_code = '0;
  logic [31:0] bc_count = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #4 clk = ~clk; // 125 MHz

  pmc_unit u_dut (
    .clk(clk), .rst(rst), .priv(priv), .inst_ret(inst_ret), .cyc_tick(cyc_tick),
    .bc_valid(bc_valid), .bc_code(bc_code), .bc_count(bc_count),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq)
  );

  // monitor: pop one expectation per returned read
  always @(negedge clk) begin
    if (reg_rvalid) begin
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data act=%h exp=none", reg_rdata);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        if (reg_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run(input int n, input logic ins, input logic cyc);
    @(negedge clk);
    inst_ret = ins; cyc_tick = cyc;
    repeat (n) @(negedge clk);
    inst_ret = 1'b0; cyc_tick = 1'b0;
  endtask

  task automatic bcast(input logic [7:0] code, input logic [31:0] cnt);
    @(negedge clk);
    bc_valid = 1'b1; bc_code = code; bc_count = cnt;
    @(negedge clk);
    bc_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    rd(8'h00, 32'h0, "R12 ctrl after reset");
    rd(8'h10, 32'h0, "R12 counter0 after reset");
    rd(8'h05, 32'h0, "R12 ovf after reset");
    chk_irq(1'b0, "R12 irq after reset");

    wr(8'h20, 32'h08); wr(8'h21, 32'h11); wr(8'h22, 32'h00); wr(8'h23, 32'hAB);
    wr(8'h01, 32'h8000_000F);
    wr(8'h01, 32'h7FFF_FFF0);
    rd(8'h01, 32'h8000_000F, "R4 enable mask, unimplemented bits zero");
    rd(8'h23, 32'hAB, "R6 other code read back");

    run(10, 1, 1);
    rd(8'h10, 32'd0, "R1 inst counter stopped");
    rd(8'h11, 32'd0, "R1 cycle-event counter stopped");
    rd(8'h07, 32'd0, "R1 cycle counter stopped");

    wr(8'h00, 32'h1);
    run(10, 1, 1);
    rd(8'h10, 32'd10, "R6 instructions counted");
    rd(8'h11, 32'd10, "R6 cycles counted");
    rd(8'h07, 32'd10, "R4 cycle counter running");
    rd(8'h13, 32'd0, "R6 other code ignores local events");
    rd(8'h12, 32'd0, "R5 software counter idle");

    wr(8'h02, 32'h2);
    rd(8'h01, 32'h8000_000D, "R4 clear-mask read");
    run(5, 1, 1);
    rd(8'h11, 32'd10, "R4 disabled counter frozen");
    rd(8'h10, 32'd15, "R4 other counter runs on");
    wr(8'h01, 32'h2);
    run(5, 1, 1);
    rd(8'h11, 32'd15, "R4 resume from frozen value");
    rd(8'h07, 32'd20, "R4 cycle counter");

    wr(8'h00, 32'h5);
    rd(8'h07, 32'd0, "R2 cycle counter zeroed");
    rd(8'h10, 32'd20, "R2 event counter kept");
    rd(8'h00, 32'h1, "R2 ctrl read");
    wr(8'h00, 32'h9);
    rd(8'h00, 32'h9, "R2 ctrl read with divide");
    run(130, 0, 1);
    rd(8'h07, 32'd2, "R3 divided by 64");
    rd(8'h11, 32'd145, "R3 event cycles undivided");
    wr(8'h00, 32'h1);
    run(3, 0, 1);
    rd(8'h07, 32'd5, "R3 undivided again");

    wr(8'h00, 32'h3);
    rd(8'h10, 32'd0, "R2 event counter0 zeroed");
    rd(8'h11, 32'd0, "R2 event counter1 zeroed");
    rd(8'h07, 32'd5, "R2 cycle counter untouched");

    wr(8'h06, 32'hC);
    rd(8'h12, 32'd1, "R5 software increment");
    rd(8'h13, 32'd0, "R5 wrong code ignores software increment");
    wr(8'h02, 32'h4); wr(8'h06, 32'h4); wr(8'h01, 32'h4);
    rd(8'h12, 32'd1, "R5 dropped while disabled");
    wr(8'h00, 32'h0); wr(8'h06, 32'h4); wr(8'h00, 32'h1);
    rd(8'h12, 32'd1, "R5 dropped while stopped");
    wr(8'h06, 32'h4);
    rd(8'h12, 32'd2, "R5 counts again");

    wr(8'h13, 32'd5);
    wr(8'h03, 32'h8);
    bcast(8'hAB, 32'hFFFF_FFFF);
    rd(8'h13, 32'd4, "R7 single-step wrap");
    rd(8'h05, 32'h8, "R8 overflow recorded");
    chk_irq(1'b1, "R9 irq raised");
    wr(8'h05, 32'h0);
    rd(8'h05, 32'h8, "R8 writing zero keeps status");
    wr(8'h05, 32'h8);
    rd(8'h05, 32'h0, "R8 write-one clears");
    chk_irq(1'b0, "R9 irq dropped");
    wr(8'h04, 32'h8);
    rd(8'h03, 32'h0, "R9 interrupt mask cleared");
    bcast(8'hAB, 32'hFFFF_FFFF);
    rd(8'h13, 32'd3, "R7 second wrap");
    rd(8'h05, 32'h8, "R8 masked overflow still recorded");
    chk_irq(1'b0, "R9 masked overflow no irq");

    bcast(8'h01, 32'd7);
    rd(8'h13, 32'd3, "R6 non-matching broadcast ignored");
    bcast(8'hAB, 32'd10);
    rd(8'h13, 32'd13, "R7 multi-count add");

    wr(8'h20, 32'h208);
    priv = 1'b1;
    run(10, 1, 0);
    rd(8'h10, 32'd0, "R10 muted at PL1");
    priv = 1'b0;
    run(10, 1, 0);
    rd(8'h10, 32'd10, "R10 counts at PL0");
    wr(8'h20, 32'h308);
    wr(8'h10, 32'hFFFF_FFFE);
    run(5, 1, 0);
    rd(8'h10, 32'hFFFF_FFFE, "R10 muted counter holds");
    rd(8'h05, 32'h8, "R10 muted counter no overflow");
    wr(8'h20, 32'h108);
    priv = 1'b1;
    run(3, 1, 0);
    rd(8'h10, 32'd1, "R10 wrap after unmute");
    rd(8'h05, 32'h9, "R8 overflow bit0 set");

    @(negedge clk);
    cyc_tick = 1'b1; reg_we = 1'b1; reg_addr = 8'h11; reg_wdata = 32'd100;
    @(negedge clk);
    cyc_tick = 1'b0; reg_we = 1'b0;
    rd(8'h11, 32'd100, "R11 load wins over increment");
    @(negedge clk);
    inst_ret = 1'b1; reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h3;
    @(negedge clk);
    inst_ret = 1'b0; reg_we = 1'b0;
    rd(8'h10, 32'd0, "R11 zeroing wins over increment");

    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard act=%0d exp=0 pending reads", sbq.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule